// File: doc/BRIEF.md
# Receive Address Filter Register File

This block holds the control word of a network receive address filter and the filter's indirectly addressed store, and decides whether an incoming frame is kept based on its destination address. Software reaches the block through a two-register bus port. Register select 0 is the control word. Register select 1 is a 16-bit data window into the filter store, at the location named by the control word's filter-address field.

The filter store holds a six-byte station address and a 512-bit multicast hash table. Both are loaded one 16-bit word at a time. A bad data write, or a request for a filter mode the block does not support, raises a one-cycle error flag. A data write that is misaligned or goes to an unmapped location changes no state.

On the frame side, a header strobe presents the destination address and a 9-bit hash index, which the receive path takes from the top bits of the destination-address CRC. One cycle later the block returns a result strobe with the accept or reject decision.

Top module: `rx_addr_filter`

## Requirements
- R1: A write with register select 0 latches the control word. Reading select 0 returns the word with these fields: bit 31 filter enable, bit 30 accept broadcast, bit 29 accept multicast, bit 28 accept unicast, bit 27 accept station match, bit 26 accept ARP, bit 25 multicast hash enable, bit 24 unicast hash request, bit 23 longest-match request, and bits 9:0 the filter address. All other bits read as 0.
- R2: Reset clears the control word, with every accept bit, the station address and the hash table. Reset also deasserts all error flags and the result strobe.
- R3: A data write (select 1) at filter address 0x000, 0x002 or 0x004 loads station byte 2k from data bits 7:0 and byte 2k+1 from bits 15:8, where k = address/2. Byte i of the station address corresponds to hdr_dst[8i+7:8i]. A data read at these addresses returns the stored word in bits 15:0.
- R4: A data write at an even address from 0x200 to 0x23E loads hash bytes b = address-0x200 (bits 7:0) and b+1 (bits 15:8). Bit j of hash byte b is hash-table bit 8b+j. A data read at these addresses returns that word.
- R5: A data write at an odd address from 0x201 to 0x23F changes no state and pulses err_align for the one cycle after the write edge.
- R6: A data write to any other filter address changes no state and pulses err_addr for the one cycle after the write edge. A data read at such an address returns 0. At most one error flag is high in any cycle.
- R7: A control write with bit 24 or bit 23 set pulses err_mode for the one cycle after the write edge. The word is still latched.
- R8: res_valid is high exactly in the cycle after a cycle with hdr_valid. The decision uses the control word and store contents as they were at that edge. res_accept is never high without res_valid.
- R9: With filter enable clear, every frame is rejected.
- R10: An address with all bits set is broadcast. It is accepted when accept-broadcast is set. An address with hdr_dst[0] set that is not broadcast is multicast and is accepted when accept-multicast is set. An address with hdr_dst[0] clear is unicast and is accepted when accept-unicast is set.
- R11: A multicast frame is accepted when hash enable is set and hash-table bit hdr_hash_idx is 1. The hash bit has no effect on broadcast or unicast frames.
- R12: With accept-station-match set, a frame whose destination equals the station address on all 48 bits is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the filter data window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| hdr_valid | input | 1 | Frame header strobe |
| hdr_dst | input | 48 | Destination address, byte i in bits 8i+7:8i |
| hdr_hash_idx | input | 9 | Hash-table bit index for this frame |
| res_valid | output | 1 | Decision strobe, one cycle after hdr_valid |
| res_accept | output | 1 | Frame accepted, qualified by res_valid |
| err_align | output | 1 | Misaligned hash-window data write (one-cycle pulse) |
| err_addr | output | 1 | Data write to an unmapped filter address (one-cycle pulse) |
| err_mode | output | 1 | Unsupported filter mode requested (one-cycle pulse) |

## Verification
Register writes take effect at the write edge. Read data is combinational, so the bench reads it back at the next falling edge after the write. The error flags are registered, so they are high only in the cycle that follows the write edge. The bench samples them at the falling edge that ends its write task. The decision is registered once: the bench raises hdr_valid for one cycle and reads res_valid and res_accept at the following falling edge, when both must be present. A write that must change nothing is checked by reading back, through the data window, the words it could have touched.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    // Filter control flags, kept in the order they sit in the control word (bit 31 down to 23).
    typedef struct packed {
        logic en;
        logic acc_bcast;
        logic acc_mcast;
        logic acc_ucast;
        logic acc_station;
        logic acc_arp;
        logic hash_en;
        logic uni_hash_req;
        logic longest_req;
    } filt_flags_t;

    localparam int FLAGS_W  = $bits(filt_flags_t);
    localparam int FLAGS_LSB = 23;

endpackage

// File: rtl/rxaf_steer.sv
// Decodes the filter address into a target within the station address or the hash table.
module rxaf_steer #(
    parameter int FADDR_W    = 10,
    parameter int HASH_BASE  = 'h200,
    parameter int HASH_BYTES = 64,
    parameter int STA_BYTES  = 6,
    localparam int SW_W      = $clog2(STA_BYTES / 2),
    localparam int HW_W      = $clog2(HASH_BYTES / 2)
) (
    input  logic [FADDR_W-1:0] faddr,
    output logic               sta_hit,
    output logic [SW_W-1:0]    sta_word,
    output logic               hash_hit,
    output logic               hash_odd,
    output logic [HW_W-1:0]    hash_word
);
    localparam logic [FADDR_W-1:0] HB    = FADDR_W'(HASH_BASE);
    localparam logic [FADDR_W-1:0] HE    = FADDR_W'(HASH_BASE + HASH_BYTES);
    localparam logic [FADDR_W-1:0] S_END = FADDR_W'(STA_BYTES);

    logic in_window;

    always_comb begin
        in_window = (faddr >= HB) && (faddr < HE);
        sta_hit   = (faddr < S_END) && !faddr[0];
        sta_word  = SW_W'(faddr >> 1);
        hash_hit  = in_window && !faddr[0];
        hash_odd  = in_window && faddr[0];
        hash_word = HW_W'((faddr - HB) >> 1);
    end
endmodule

// File: rtl/rxaf_store.sv
// Station address and multicast hash table, written one 16-bit word at a time.
module rxaf_store #(
    parameter int STA_BYTES  = 6,
    parameter int HASH_BYTES = 64,
    localparam int STA_W     = STA_BYTES * 8,
    localparam int HASH_BITS = HASH_BYTES * 8,
    localparam int SW_W      = $clog2(STA_BYTES / 2),
    localparam int HW_W      = $clog2(HASH_BYTES / 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [15:0]          wr_word,
    input  logic                 sta_hit,
    input  logic [SW_W-1:0]      sta_word,
    input  logic                 hash_hit,
    input  logic [HW_W-1:0]      hash_word,
    output logic [STA_W-1:0]     station,
    output logic [HASH_BITS-1:0] hash_tbl,
    output logic [15:0]          rd_word
);
    typedef struct packed {
        logic [STA_W-1:0]     sta;
        logic [HASH_BITS-1:0] hash;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && sta_hit) begin
            st_d.sta[{sta_word, 4'b0000} +: 16] = wr_word;
        end
        if (wr_en && hash_hit) begin
            st_d.hash[{hash_word, 4'b0000} +: 16] = wr_word;
        end
        if (sta_hit) begin
            rd_word = st_q.sta[{sta_word, 4'b0000} +: 16];
        end else if (hash_hit) begin
            rd_word = st_q.hash[{hash_word, 4'b0000} +: 16];
        end else begin
            rd_word = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign station  = st_q.sta;
    assign hash_tbl = st_q.hash;
endmodule

// File: rtl/rxaf_match.sv
// Accept/reject decision for one destination address, registered once.
module rxaf_match #(
    parameter int STA_BYTES  = 6,
    parameter int HASH_BYTES = 64,
    localparam int STA_W     = STA_BYTES * 8,
    localparam int HASH_BITS = HASH_BYTES * 8,
    localparam int IDX_W     = $clog2(HASH_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 acc_bcast,
    input  logic                 acc_mcast,
    input  logic                 acc_ucast,
    input  logic                 acc_station,
    input  logic                 hash_en,
    input  logic [STA_W-1:0]     station,
    input  logic [HASH_BITS-1:0] hash_tbl,
    input  logic                 hdr_valid,
    input  logic [STA_W-1:0]     hdr_dst,
    input  logic [IDX_W-1:0]     hdr_hash_idx,
    output logic                 res_valid,
    output logic                 res_accept
);
    typedef struct packed {
        logic valid;
        logic accept;
    } res_t;

    res_t r_d, r_q;
    logic [STA_BYTES-1:0] byte_eq;
    logic is_bcast, is_mcast, is_ucast, sta_eq, hash_bit;

    // One comparator per address byte.
    for (genvar b = 0; b < STA_BYTES; b++) begin : g_byte_eq
        assign byte_eq[b] = (hdr_dst[b*8 +: 8] == station[b*8 +: 8]);
    end

    always_comb begin
        is_bcast = &hdr_dst;
        is_mcast = hdr_dst[0] && !is_bcast;
        is_ucast = !hdr_dst[0];
        sta_eq   = &byte_eq;
        hash_bit = hash_tbl[hdr_hash_idx];

        r_d.valid  = hdr_valid;
        r_d.accept = hdr_valid && en &&
                     ((is_bcast && acc_bcast) ||
                      (is_mcast && acc_mcast) ||
                      (is_mcast && hash_en && hash_bit) ||
                      (is_ucast && acc_ucast) ||
                      (acc_station && sta_eq));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign res_valid  = r_q.valid;
    assign res_accept = r_q.accept;
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
    parameter int FADDR_W    = 10,
    parameter int HASH_BASE  = 'h200,
    parameter int HASH_BYTES = 64,
    parameter int STA_BYTES  = 6,
    localparam int REG_W     = 32,
    localparam int STA_W     = STA_BYTES * 8,
    localparam int HASH_BITS = HASH_BYTES * 8,
    localparam int IDX_W     = $clog2(HASH_BITS),
    localparam int SW_W      = $clog2(STA_BYTES / 2),
    localparam int HW_W      = $clog2(HASH_BYTES / 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             hdr_valid,
    input  logic [STA_W-1:0] hdr_dst,
    input  logic [IDX_W-1:0] hdr_hash_idx,
    output logic             res_valid,
    output logic             res_accept,
    output logic             err_align,
    output logic             err_addr,
    output logic             err_mode
);
    import rxaf_pkg::*;

    typedef struct packed {
        filt_flags_t        flags;
        logic [FADDR_W-1:0] faddr;
        logic               err_align;
        logic               err_addr;
        logic               err_mode;
    } regs_t;

    regs_t rg_d, rg_q;

    logic                 sta_hit, hash_hit, hash_odd, data_wr;
    logic [SW_W-1:0]      sta_word;
    logic [HW_W-1:0]      hash_word;
    logic [STA_W-1:0]     station;
    logic [HASH_BITS-1:0] hash_tbl;
    logic [15:0]          rd_word;
    logic [REG_W-1:0]     ctrl_word;
    logic                 unused_wbits;

    assign unused_wbits = ^reg_wdata[FLAGS_LSB-1:FADDR_W];
    assign data_wr      = reg_wr && reg_sel;

    rxaf_steer #(
        .FADDR_W(FADDR_W), .HASH_BASE(HASH_BASE),
        .HASH_BYTES(HASH_BYTES), .STA_BYTES(STA_BYTES)
    ) u_steer (
        .faddr(rg_q.faddr), .sta_hit(sta_hit), .sta_word(sta_word),
        .hash_hit(hash_hit), .hash_odd(hash_odd), .hash_word(hash_word)
    );

    rxaf_store #(.STA_BYTES(STA_BYTES), .HASH_BYTES(HASH_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_word(reg_wdata[15:0]),
        .sta_hit(sta_hit), .sta_word(sta_word),
        .hash_hit(hash_hit), .hash_word(hash_word),
        .station(station), .hash_tbl(hash_tbl), .rd_word(rd_word)
    );

    rxaf_match #(.STA_BYTES(STA_BYTES), .HASH_BYTES(HASH_BYTES)) u_match (
        .clk(clk), .rst_n(rst_n),
        .en(rg_q.flags.en), .acc_bcast(rg_q.flags.acc_bcast),
        .acc_mcast(rg_q.flags.acc_mcast), .acc_ucast(rg_q.flags.acc_ucast),
        .acc_station(rg_q.flags.acc_station), .hash_en(rg_q.flags.hash_en),
        .station(station), .hash_tbl(hash_tbl),
        .hdr_valid(hdr_valid), .hdr_dst(hdr_dst), .hdr_hash_idx(hdr_hash_idx),
        .res_valid(res_valid), .res_accept(res_accept)
    );

    always_comb begin
        rg_d           = rg_q;
        rg_d.err_align = 1'b0;
        rg_d.err_addr  = 1'b0;
        rg_d.err_mode  = 1'b0;
        if (reg_wr && !reg_sel) begin
            rg_d.flags    = filt_flags_t'(reg_wdata[REG_W-1:FLAGS_LSB]);
            rg_d.faddr    = reg_wdata[FADDR_W-1:0];
            rg_d.err_mode = reg_wdata[FLAGS_LSB+1] | reg_wdata[FLAGS_LSB];
        end
        if (data_wr) begin
            rg_d.err_align = hash_odd;
            rg_d.err_addr  = !sta_hit && !hash_hit && !hash_odd;
        end

        ctrl_word                          = '0;
        ctrl_word[REG_W-1:FLAGS_LSB]       = rg_q.flags;
        ctrl_word[FADDR_W-1:0]             = rg_q.faddr;
        reg_rdata = reg_sel ? {{(REG_W-16){1'b0}}, rd_word} : ctrl_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign err_align = rg_q.err_align;
    assign err_addr  = rg_q.err_addr;
    assign err_mode  = rg_q.err_mode;
endmodule

// File: rtl/rxaf_chk.sv
module rxaf_chk #(
    parameter int STA_W     = 48,
    parameter int HASH_BITS = 512
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic                 reg_sel,
    input logic                 hdr_valid,
    input logic                 res_valid,
    input logic                 res_accept,
    input logic                 err_align,
    input logic                 err_addr,
    input logic                 err_mode,
    input logic                 filt_en,
    input logic [STA_W-1:0]     station,
    input logic [HASH_BITS-1:0] hash_tbl
);
    p_res_follows_hdr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid);
    p_no_spurious_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid);
    p_accept_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> res_valid);
    p_disabled_rejects_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !filt_en) |=> !res_accept);
    p_align_keeps_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_align |-> ($stable(station) && $stable(hash_tbl)));
    p_addr_keeps_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_addr |-> ($stable(station) && $stable(hash_tbl)));
    p_err_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_align, err_addr, err_mode}));
    p_mode_from_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> $past(reg_wr && !reg_sel));
    p_data_err_from_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_align || err_addr) |-> $past(reg_wr && reg_sel));
endmodule

bind rx_addr_filter rxaf_chk #(.STA_W(STA_BYTES * 8), .HASH_BITS(HASH_BYTES * 8)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .hdr_valid(hdr_valid), .res_valid(res_valid), .res_accept(res_accept),
    .err_align(err_align), .err_addr(err_addr), .err_mode(err_mode),
    .filt_en(rg_q.flags.en), .station(station), .hash_tbl(hash_tbl)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STA   = 48'h5544_3322_1102;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h0000_0000_0001;
    localparam logic [47:0] UCAST = 48'h0000_0000_0010;
    localparam int NVEC = 12;
    // {control word, destination, hash index, expected accept}
    localparam logic [89:0] VEC [NVEC] = '{
        {32'h8000_0000, BCAST, 9'd0,   1'b0},
        {32'hC000_0000, BCAST, 9'd0,   1'b1},
        {32'hA000_0000, MCAST, 9'd0,   1'b1},
        {32'hC000_0000, MCAST, 9'd0,   1'b0},
        {32'hA000_0000, BCAST, 9'd0,   1'b0},
        {32'h8200_0000, MCAST, 9'd165, 1'b1},
        {32'h8200_0000, MCAST, 9'd164, 1'b0},
        {32'h8200_0000, UCAST, 9'd165, 1'b0},
        {32'h9000_0000, UCAST, 9'd0,   1'b1},
        {32'h8800_0000, STA,   9'd0,   1'b1},
        {32'h8800_0000, 48'h5544_3322_1002, 9'd0, 1'b0},
        {32'h7E00_0000, BCAST, 9'd165, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hdr_valid = 1'b0;
    logic [47:0] hdr_dst = '0;
    logic [8:0]  hdr_hash_idx = '0;
    logic        res_valid, res_accept, err_align, err_addr, err_mode;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hdr_valid(hdr_valid), .hdr_dst(hdr_dst), .hdr_hash_idx(hdr_hash_idx),
        .res_valid(res_valid), .res_accept(res_accept),
        .err_align(err_align), .err_addr(err_addr), .err_mode(err_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic frame(input logic [47:0] dst, input logic [8:0] idx,
                         output logic vld, output logic acc);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_dst = dst; hdr_hash_idx = idx;
        @(negedge clk);
        vld = res_valid; acc = res_accept;
        hdr_valid = 1'b0;
    endtask

    task automatic errs_now(input string tag, input logic [2:0] exp);
        check(tag, {29'd0, err_align, err_addr, err_mode}, {29'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic vld, acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        rd(1'b0, d); check("R2 ctrl after reset", d, 32'h0);
        rd(1'b1, d); check("R2 station word0 after reset", d, 32'h0);
        errs_now("R2 error flags after reset", 3'b000);
        check("R2 result strobe after reset", {31'd0, res_valid}, 32'd0);

        // R1: control readback, reserved bits read zero
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, d); check("R1 ctrl readback", d, 32'hFF80_03FF);
        errs_now("R7 err_mode on full word", 3'b001);
        @(negedge clk);
        errs_now("R7 err_mode lasts one cycle", 3'b000);

        // R3: station address load
        wr(1'b0, 32'h0000_0000); wr(1'b1, 32'h0000_1102);
        wr(1'b0, 32'h0000_0002); wr(1'b1, 32'h0000_3322);
        wr(1'b0, 32'h0000_0004); wr(1'b1, 32'h0000_5544);
        errs_now("R3 no error on station write", 3'b000);
        rd(1'b1, d); check("R3 station word at 0x004", d, 32'h5544);
        wr(1'b0, 32'h0000_0000);
        rd(1'b1, d); check("R3 station word at 0x000", d, 32'h1102);

        // R4: hash table load, bit 165 and bit 511
        wr(1'b0, 32'h0000_0214); wr(1'b1, 32'h0000_0020);
        rd(1'b1, d); check("R4 hash word at 0x214", d, 32'h0020);
        wr(1'b0, 32'h0000_023E); wr(1'b1, 32'h0000_8000);
        rd(1'b1, d); check("R4 hash word at 0x23E", d, 32'h8000);

        // R5: odd address in hash window
        wr(1'b0, 32'h0000_0201); wr(1'b1, 32'h0000_BEEF);
        errs_now("R5 err_align pulse", 3'b100);
        rd(1'b1, d); check("R5 odd read returns 0", d, 32'h0);
        wr(1'b0, 32'h0000_0200);
        rd(1'b1, d); check("R5 hash word 0x200 unchanged", d, 32'h0);
        errs_now("R5 err_align cleared", 3'b000);

        // R6: unmapped addresses
        wr(1'b0, 32'h0000_0006); wr(1'b1, 32'h0000_ABCD);
        errs_now("R6 err_addr pulse at 0x006", 3'b010);
        rd(1'b1, d); check("R6 unmapped read returns 0", d, 32'h0);
        wr(1'b0, 32'h0000_0004);
        rd(1'b1, d); check("R6 station unchanged", d, 32'h5544);
        wr(1'b0, 32'h0000_0240); wr(1'b1, 32'h0000_FFFF);
        errs_now("R6 err_addr pulse past window", 3'b010);
        wr(1'b0, 32'h0000_023E);
        rd(1'b1, d); check("R6 last hash word unchanged", d, 32'h8000);
        wr(1'b0, 32'h0000_0003); wr(1'b1, 32'h0000_1234);
        errs_now("R6 err_addr pulse at odd station addr", 3'b010);

        // R7: unsupported modes, each alone
        wr(1'b0, 32'h0100_0000);
        errs_now("R7 err_mode for unicast hash", 3'b001);
        rd(1'b0, d); check("R7 word latched", d, 32'h0100_0000);
        wr(1'b0, 32'h0080_0000);
        errs_now("R7 err_mode for longest match", 3'b001);

        // R8..R12: decision vectors
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b0, VEC[i][89:58]);
            frame(VEC[i][57:10], VEC[i][9:1], vld, acc);
            check($sformatf("R8 res_valid vector %0d", i), {31'd0, vld}, 32'd1);
            check($sformatf("R9/R10/R11/R12 accept vector %0d", i), {31'd0, acc}, {31'd0, VEC[i][0]});
        end

        // R11: top hash bit
        wr(1'b0, 32'h8200_0000);
        frame(MCAST, 9'd511, vld, acc);
        check("R11 hash bit 511 accepts", {31'd0, acc}, 32'd1);

        // R8: no result without a header
        @(negedge clk);
        check("R8 no result without header", {31'd0, res_valid}, 32'd0);

        // R2: reset mid-run clears store
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        wr(1'b0, 32'h0000_0004);
        rd(1'b1, d); check("R2 station cleared by reset", d, 32'h0);
        wr(1'b0, 32'hC000_0000);
        frame(BCAST, 9'd0, vld, acc);
        check("R2 accept after reset uses new ctrl", {31'd0, acc}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule